// File: doc/BRIEF.md
# Optical Port Transmit Modulator

This block produces the drive value for an infrared transmit pad. One of four internal digital sources is selected: the serial transmit line, a general-purpose output bit, or one of two energy pulse lines. The block either forwards the selected source unchanged or uses it to gate a carrier near 38 kHz whose high time is programmable. A polarity bit may invert the final transmit value. A map bit can give the pad to an LCD segment driver, whose waveform arrives on a separate input.

The transmit path ends in a single pad register, so every pad change comes from a clock edge. The carrier counter is held at zero while modulation is off, so each modulated burst begins at the start of a carrier period with the carrier high. The receive side gates the incoming optical level with a disable bit and can invert it before it reaches the serial receiver. While disabled, it presents the idle (mark) level.

Top module: `ir_pad_modulator`

## Requirements
- R1: `srcSel` picks the transmit source: 0 serial transmit line, 1 general-purpose output bit, 2 pulse line A, 3 pulse line B.
- R2: With `modEn` = 0, `lcdMap` = 0 and `txInv` = 0, `padOut` equals the selected source.
- R3: With `modEn` = 1 and `lcdMap` = 0, `padOut` is the selected source ANDed with a carrier that repeats every `CARRIER_PERIOD` clock cycles.
- R4: The carrier is high for the first `CARRIER_PERIOD*(4-dutyCode)/8` cycles of each period: code 0 gives 50%, code 1 gives 37.5%, code 2 gives 25% and code 3 gives 12.5%.
- R5: With `txInv` = 1 and `lcdMap` = 0, `padOut` is the complement of the value that R2 or R3 would give.
- R6: With `lcdMap` = 1, `padOut` follows `lcdSeg`, and source, modulation and inversion have no effect.
- R7: While `modEn` = 0 the carrier phase is held at the period start, so the first cycle after `modEn` rises is a carrier-high cycle.
- R8: `rxToUart` equals `rxPad XOR rxInv` when `rxDis` = 0, and equals the idle level `RX_IDLE` (default 1) when `rxDis` = 1. This path is combinational.
- R9: During reset and after it, `padOut` is 0 and the carrier phase is at the period start.
- R10: `padOut` reflects the inputs and carrier phase of the previous clock edge, with exactly one register of latency. A change to an input between edges does not move `padOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| uartTx | input | 1 | Serial port transmit line (source 0) |
| gpioOut | input | 1 | General-purpose output bit (source 1) |
| pulseA | input | 1 | Energy pulse line A (source 2) |
| pulseB | input | 1 | Energy pulse line B (source 3) |
| srcSel | input | 2 | Transmit source select |
| modEn | input | 1 | Carrier modulation enable |
| dutyCode | input | 2 | Carrier high-time code |
| txInv | input | 1 | Transmit polarity invert |
| lcdMap | input | 1 | 1 hands the pad to the LCD segment driver |
| lcdSeg | input | 1 | LCD segment waveform |
| rxPad | input | 1 | Optical receive pad level |
| rxDis | input | 1 | Receive disable |
| rxInv | input | 1 | Receive polarity invert |
| padOut | output | 1 | Registered transmit pad drive |
| rxToUart | output | 1 | Level delivered to the serial receive input |

## Verification
The bench builds the block with `CARRIER_PERIOD` = 16 instead of the 38 kHz default of 2632. A full carrier period then lasts only sixteen cycles. Bursts that straddle several wraps, and every duty code counted over complete periods, fit in a short run. Random toggling of the modulation enable lands many burst starts at unrelated phases, which exercises the phase-hold rule.

// File: rtl/ir_pkg.sv
package ir_pkg;

  // Transmit source encodings; the value is the mux index.
  typedef enum logic [1:0] {
    SRC_UART    = 2'd0,
    SRC_GPIO    = 2'd1,
    SRC_PULSE_A = 2'd2,
    SRC_PULSE_B = 2'd3
  } irSrc_e;

  // Duty codes; high eighths = 4 - code.
  typedef enum logic [1:0] {
    DUTY_50   = 2'd0,
    DUTY_37P5 = 2'd1,
    DUTY_25   = 2'd2,
    DUTY_12P5 = 2'd3
  } irDuty_e;

  // Strobes handed from carrier control to the datapath.
  typedef struct packed {
    logic gateOpen;     // selected source may reach the pad this cycle
    logic periodStart;  // carrier phase is at the first cycle of a period
  } irStrobe_t;

endpackage

// File: rtl/ir_carrier_ctrl.sv
module ir_carrier_ctrl
  import ir_pkg::*;
#(
  parameter int CARRIER_PERIOD = 2632
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modEn,
  input  logic [1:0] dutyCode,
  output irStrobe_t  strobe
);

  localparam int CNT_W  = (CARRIER_PERIOD > 2) ? $clog2(CARRIER_PERIOD) : 1;
  localparam int EIGHTH = CARRIER_PERIOD / 8;
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(CARRIER_PERIOD - 1);
  localparam logic [CNT_W-1:0] HI_50   = CNT_W'(EIGHTH * 4);
  localparam logic [CNT_W-1:0] HI_37P5 = CNT_W'(EIGHTH * 3);
  localparam logic [CNT_W-1:0] HI_25   = CNT_W'(EIGHTH * 2);
  localparam logic [CNT_W-1:0] HI_12P5 = CNT_W'(EIGHTH);

  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] hiCount;

  // Phase counter: parked at zero while modulation is off.
  always_ff @(posedge clk) begin
    if (!rstN)                phaseCnt <= '0;
    else if (!modEn)          phaseCnt <= '0;
    else if (phaseCnt == LAST) phaseCnt <= '0;
    else                      phaseCnt <= phaseCnt + 1'b1;
  end

  always_comb begin
    unique case (irDuty_e'(dutyCode))
      DUTY_50:   hiCount = HI_50;
      DUTY_37P5: hiCount = HI_37P5;
      DUTY_25:   hiCount = HI_25;
      DUTY_12P5: hiCount = HI_12P5;
      default:   hiCount = HI_50;
    endcase
  end

  always_comb begin
    strobe.gateOpen    = !modEn || (phaseCnt < hiCount);
    strobe.periodStart = modEn && (phaseCnt == '0);
  end

  // R7
  held_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modEn |=> (phaseCnt == '0));

  // R3
  period_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modEn && phaseCnt == LAST) |=> (phaseCnt == '0));

  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseCnt <= LAST);

  // R4
  duty_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modEn && phaseCnt == hiCount) |-> !strobe.gateOpen);

  // R9
  reset_phase_chk: assert property (@(posedge clk)
    !rstN |=> (phaseCnt == '0));

endmodule

// File: rtl/ir_path_dp.sv
module ir_path_dp
  import ir_pkg::*;
#(
  parameter int       NUM_SRC = 4,
  parameter bit       RX_IDLE = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       uartTx,
  input  logic       gpioOut,
  input  logic       pulseA,
  input  logic       pulseB,
  input  logic [1:0] srcSel,
  input  logic       txInv,
  input  logic       lcdMap,
  input  logic       lcdSeg,
  input  irStrobe_t  strobe,
  input  logic       rxPad,
  input  logic       rxDis,
  input  logic       rxInv,
  output logic       padOut,
  output logic       rxToUart
);

  localparam int SEL_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] srcVec;
  logic               selSrc;
  logic               txLevel;
  logic               padNext;
  logic               padQ;

  // Source vector, indexed by the select encoding.
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    if (gi == int'(SRC_UART))         begin : g_u assign srcVec[gi] = uartTx;  end
    else if (gi == int'(SRC_GPIO))    begin : g_g assign srcVec[gi] = gpioOut; end
    else if (gi == int'(SRC_PULSE_A)) begin : g_a assign srcVec[gi] = pulseA;  end
    else                              begin : g_b assign srcVec[gi] = pulseB;  end
  end

  always_comb begin
    selSrc  = srcVec[srcSel[SEL_W-1:0]];
    txLevel = (selSrc & strobe.gateOpen) ^ txInv;
    padNext = lcdMap ? lcdSeg : txLevel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) padQ <= 1'b0;
    else       padQ <= padNext;
  end

  assign padOut   = padQ;
  assign rxToUart = rxDis ? RX_IDLE : (rxPad ^ rxInv);

  // R6
  lcd_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    lcdMap |=> (padQ == $past(lcdSeg)));

  // R2
  gate_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lcdMap && strobe.gateOpen && !txInv) |=> (padQ == $past(selSrc)));

  // R5
  gate_shut_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lcdMap && !strobe.gateOpen) |=> (padQ == $past(txInv)));

  // R7
  start_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.periodStart |-> strobe.gateOpen);

  // R8
  rx_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDis |-> (rxToUart == RX_IDLE));

  // R9
  reset_pad_chk: assert property (@(posedge clk)
    !rstN |=> !padQ);

endmodule

// File: rtl/ir_pad_modulator.sv
module ir_pad_modulator
  import ir_pkg::*;
#(
  parameter int CARRIER_PERIOD = 2632,
  parameter bit RX_IDLE        = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       uartTx,
  input  logic       gpioOut,
  input  logic       pulseA,
  input  logic       pulseB,
  input  logic [1:0] srcSel,
  input  logic       modEn,
  input  logic [1:0] dutyCode,
  input  logic       txInv,
  input  logic       lcdMap,
  input  logic       lcdSeg,
  input  logic       rxPad,
  input  logic       rxDis,
  input  logic       rxInv,
  output logic       padOut,
  output logic       rxToUart
);

  irStrobe_t carrierStrobe;

  ir_carrier_ctrl #(
    .CARRIER_PERIOD(CARRIER_PERIOD)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modEn    (modEn),
    .dutyCode (dutyCode),
    .strobe   (carrierStrobe)
  );

  ir_path_dp #(
    .NUM_SRC (4),
    .RX_IDLE (RX_IDLE)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .uartTx   (uartTx),
    .gpioOut  (gpioOut),
    .pulseA   (pulseA),
    .pulseB   (pulseB),
    .srcSel   (srcSel),
    .txInv    (txInv),
    .lcdMap   (lcdMap),
    .lcdSeg   (lcdSeg),
    .strobe   (carrierStrobe),
    .rxPad    (rxPad),
    .rxDis    (rxDis),
    .rxInv    (rxInv),
    .padOut   (padOut),
    .rxToUart (rxToUart)
  );

endmodule

// File: tb/test_ir_pad_modulator.sv
module test_ir_pad_modulator;

  localparam int P = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uartTx = 0, gpioOut = 0, pulseA = 0, pulseB = 0;
  logic [1:0] srcSel = 0, dutyCode = 0;
  logic modEn = 0, txInv = 0, lcdMap = 0, lcdSeg = 0;
  logic rxPad = 0, rxDis = 1, rxInv = 0;
  logic padOut, rxToUart;

  int vecs = 0;
  int errs = 0;
  int mCnt = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ir_pad_modulator #(.CARRIER_PERIOD(P), .RX_IDLE(1'b1)) i_ir_pad_modulator (
    .clk(clk), .rstN(rstN), .uartTx(uartTx), .gpioOut(gpioOut),
    .pulseA(pulseA), .pulseB(pulseB), .srcSel(srcSel), .modEn(modEn),
    .dutyCode(dutyCode), .txInv(txInv), .lcdMap(lcdMap), .lcdSeg(lcdSeg),
    .rxPad(rxPad), .rxDis(rxDis), .rxInv(rxInv),
    .padOut(padOut), .rxToUart(rxToUart)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic modelSrc();
    case (srcSel)
      2'd0: return uartTx;
      2'd1: return gpioOut;
      2'd2: return pulseA;
      default: return pulseB;
    endcase
  endfunction

  function automatic logic modelPad();
    logic carrier;
    logic tx;
    carrier = (mCnt < (P / 8) * (4 - int'(dutyCode)));
    tx = (modEn ? (modelSrc() & carrier) : modelSrc()) ^ txInv;
    return lcdMap ? lcdSeg : tx;
  endfunction

  function automatic logic modelRx();
    return rxDis ? 1'b1 : (rxPad ^ rxInv);
  endfunction

  // Called at a negedge with inputs set: predicts padOut after the next posedge.
  task automatic step(input string reqIn);
    string req;
    logic exp;
    req = reqIn;
    if (req == "") req = lcdMap ? "R6" : (txInv ? "R5" : (modEn ? "R3" : "R2"));
    exp = modelPad();
    if (!modEn) mCnt = 0;
    else if (mCnt == P - 1) mCnt = 0;
    else mCnt = mCnt + 1;
    @(negedge clk);
    chk(req, padOut, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int highs;
    void'($urandom(32'd2361));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", padOut, 1'b0);
    chk("R8", rxToUart, 1'b1);
    rstN = 1;
    mCnt = 0;
    @(negedge clk);
    chk("R9", padOut, 1'b0);

    // R1: one-hot sources under each select value, then the complement
    for (int s = 0; s < 4; s++) begin
      srcSel = 2'(s);
      {pulseB, pulseA, gpioOut, uartTx} = 4'b0001 << s;
      step("R1");
      {pulseB, pulseA, gpioOut, uartTx} = ~(4'b0001 << s);
      step("R1");
    end

    // R4 / R7: count carrier-high cycles over one full period per code
    srcSel = 2'd0; uartTx = 1;
    for (int c = 0; c < 4; c++) begin
      modEn = 0; dutyCode = 2'(c);
      step("R2");
      modEn = 1;
      step("R7");
      chk("R7", padOut, 1'b1);
      highs = int'(padOut);
      for (int k = 1; k < P; k++) begin
        step("R4");
        highs += int'(padOut);
      end
      chk("R4", (highs == (P / 8) * (4 - c)), 1'b1);
    end
    modEn = 0;
    step("");

    // R10: input change between edges does not move padOut
    lcdMap = 1; lcdSeg = ~padOut;
    begin
      logic held;
      held = padOut;
      #1 chk("R10", padOut, held);
    end
    step("R6");

    // R5: inversion with gate closed and open
    lcdMap = 0; txInv = 1; uartTx = 0;
    step("R5");
    uartTx = 1;
    step("R5");
    txInv = 0;

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      {pulseB, pulseA, gpioOut, uartTx} = 4'($urandom);
      lcdSeg = 1'($urandom);
      rxPad = 1'($urandom);
      rxDis = 1'($urandom);
      rxInv = 1'($urandom);
      if ($urandom % 4 == 0) srcSel = 2'($urandom);
      if ($urandom % 20 == 0) lcdMap = ~lcdMap;
      if ($urandom % 30 == 0) txInv = ~txInv;
      if ($urandom % 50 == 0) modEn = ~modEn;
      if ($urandom % 60 == 0) dutyCode = 2'($urandom);
      #1 chk("R8", rxToUart, modelRx());
      step("");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule